// File: doc/BRIEF.md
# Per-Line Use-Lockout Timer Table

This block keeps a small table of cache line addresses, each held in a lockout window for a fixed number of cycles after the local cache gains exclusive ownership of the line. While an address is locked, the surrounding coherence controller defers remote forwarded requests and replacements for that line. This gives the local core a guaranteed window in which to use the line before it can be taken away.

The controller arms a slot by presenting a line address. A per-slot down-counter holds the remaining time. When the window has elapsed, the table raises a one-cycle ready pulse carrying the address, so the controller can fire its timeout event. The entry keeps its slot until the controller clears it by address. A clear removes an entry before or after it fires. A registered query port tells the controller whether a given address is still inside its window.

The table only keeps time and records which addresses are armed. It never decides which requests to defer.

Top module: `lockout_timer_table`

## Requirements
- R1: While reset is high, and in the first cycle after it is released, ready_valid, full and query_locked are 0, and every slot is empty. An entry armed before a reset never produces a ready pulse afterwards.
- R2: An address armed at clock edge E (arm_valid high at E) appears on ready_addr, with ready_valid high, in the cycle that follows edge E+LOCK_CYCLES.
- R3: Each arming produces exactly one ready pulse, one cycle long, even when the entry is never cleared. Once the pulse has been given, the address no longer reads as locked.
- R4: Arming an address that already holds a slot restarts its window from the new arm edge. No second slot is taken, and only the restarted deadline produces a pulse.
- R5: A clear (clear_valid with clear_addr) removes the matching entry. It then never pulses, no longer reads as locked, and its slot becomes free, so full drops.
- R6: When arm and clear name the same address at the same edge, the arm wins and the window restarts from that edge.
- R7: full is 1 exactly when all ENTRIES slots are occupied. Fired entries that have not been cleared still count. An arm of an address not in the table while full is high is ignored and never pulses.
- R8: query_locked is registered. In the cycle after edge E it is 1 exactly when query_addr, sampled at E, matched an occupied slot whose pulse had not yet been given.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| arm_valid | input | 1 | Arm or restart a lockout window for arm_addr |
| arm_addr | input | ADDR_W | Line address to lock |
| clear_valid | input | 1 | Remove the entry holding clear_addr |
| clear_addr | input | ADDR_W | Line address to remove |
| query_addr | input | ADDR_W | Line address whose lock status is wanted |
| query_locked | output | 1 | Registered: queried address is still in its window |
| full | output | 1 | All slots occupied |
| ready_valid | output | 1 | One-cycle pulse: a window has elapsed |
| ready_addr | output | ADDR_W | Address whose window elapsed |

## Verification
The hardest conditions to reach are the collisions on a single slot: a restart that lands while an older deadline is still pending, and an arm and a clear of the same address at the same edge. The stimulus reaches them by arming one address twice a few cycles apart, then arming another and issuing arm and clear together on a later edge. A monitor logs every ready pulse with its cycle number, so the bench can show that only the later deadline fires. The full-table case is reached by leaving fired entries uncleared, so that a fifth address finds no slot and must stay silent.

// File: rtl/lockout_pkg.sv
package lockout_pkg;
  typedef struct packed {
    logic valid;
    logic fired;
  } slot_flags_t;
endpackage

// File: rtl/lockout_pick.sv
module lockout_pick #(
  parameter int N = 4
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] grant,
  output logic         any
);
  always_comb begin
    grant = req & (~req + N'(1));
    any   = |req;
  end
endmodule

// File: rtl/lockout_slot.sv
module lockout_slot
  import lockout_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 7,
  parameter int LOAD_V = 49
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              drop,
  input  logic              take,
  output slot_flags_t       flags,
  output logic [ADDR_W-1:0] addr_q,
  output logic              expired
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      flags  <= '0;
      cnt    <= '0;
      addr_q <= '0;
    end else if (load) begin
      flags.valid <= 1'b1;
      flags.fired <= 1'b0;
      cnt         <= CNT_W'(LOAD_V);
      addr_q      <= addr_in;
    end else if (drop) begin
      flags <= '0;
      cnt   <= '0;
    end else begin
      if (take) flags.fired <= 1'b1;
      if (cnt != '0) cnt <= cnt - CNT_W'(1);
    end
  end

  always_comb expired = flags.valid && !flags.fired && (cnt == '0);
endmodule

// File: rtl/lockout_timer_table.sv
module lockout_timer_table
  import lockout_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int ENTRIES     = 4,
  parameter int LOCK_CYCLES = 50
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              arm_valid,
  input  logic [ADDR_W-1:0] arm_addr,
  input  logic              clear_valid,
  input  logic [ADDR_W-1:0] clear_addr,
  input  logic [ADDR_W-1:0] query_addr,
  output logic              query_locked,
  output logic              full,
  output logic              ready_valid,
  output logic [ADDR_W-1:0] ready_addr
);
  localparam int CNT_W  = $clog2(LOCK_CYCLES + 1) + 1;
  localparam int LOAD_V = (LOCK_CYCLES > 0) ? LOCK_CYCLES - 1 : 0;

  slot_flags_t                    flags   [ENTRIES];
  logic [ENTRIES-1:0][ADDR_W-1:0] slot_addr;
  logic [ENTRIES-1:0]             slot_valid, slot_live, expired;
  logic [ENTRIES-1:0]             arm_hit, clr_hit, qry_hit;
  logic [ENTRIES-1:0]             alloc, fire_sel, load, drop;
  logic                           hit_any, alloc_any, fire_any;
  logic [ADDR_W-1:0]              fire_addr;

  for (genvar i = 0; i < ENTRIES; i++) begin : g_slot
    lockout_slot #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .LOAD_V(LOAD_V)) u_slot (
      .clk(clk), .rst(rst), .load(load[i]), .addr_in(arm_addr),
      .drop(drop[i]), .take(fire_sel[i]), .flags(flags[i]),
      .addr_q(slot_addr[i]), .expired(expired[i])
    );
    always_comb begin
      slot_valid[i] = flags[i].valid;
      slot_live[i]  = flags[i].valid && !flags[i].fired;
      arm_hit[i]    = flags[i].valid && (slot_addr[i] == arm_addr);
      clr_hit[i]    = flags[i].valid && (slot_addr[i] == clear_addr);
      qry_hit[i]    = slot_live[i]   && (slot_addr[i] == query_addr);
      load[i]       = arm_valid && (arm_hit[i] || (!hit_any && alloc[i]));
      drop[i]       = clear_valid && clr_hit[i];
    end
  end

  always_comb hit_any = |arm_hit;

  lockout_pick #(.N(ENTRIES)) u_free_pick (
    .req(~slot_valid), .grant(alloc), .any(alloc_any)
  );

  lockout_pick #(.N(ENTRIES)) u_fire_pick (
    .req(expired), .grant(fire_sel), .any(fire_any)
  );

  always_comb begin
    fire_addr = '0;
    for (int i = 0; i < ENTRIES; i++)
      if (fire_sel[i]) fire_addr = fire_addr | slot_addr[i];
  end

  always_comb full = !alloc_any;

  always_ff @(posedge clk) begin
    if (rst) begin
      ready_valid  <= 1'b0;
      ready_addr   <= '0;
      query_locked <= 1'b0;
    end else begin
      ready_valid  <= fire_any;
      ready_addr   <= fire_addr;
      query_locked <= |qry_hit;
    end
  end
endmodule

// File: rtl/lockout_timer_table_chk.sv
module lockout_timer_table_chk #(
  parameter int ADDR_W  = 16,
  parameter int ENTRIES = 4
) (
  input logic                           clk,
  input logic                           rst,
  input logic                           arm_valid,
  input logic [ADDR_W-1:0]              arm_addr,
  input logic                           clear_valid,
  input logic [ADDR_W-1:0]              clear_addr,
  input logic                           query_locked,
  input logic                           full,
  input logic                           ready_valid,
  input logic [ADDR_W-1:0]              ready_addr,
  input logic [ENTRIES-1:0]             slot_valid,
  input logic [ENTRIES-1:0][ADDR_W-1:0] slot_addr
);
  logic dup, in_table;

  always_comb begin
    dup      = 1'b0;
    in_table = 1'b0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (slot_valid[i] && slot_addr[i] == arm_addr) in_table = 1'b1;
      for (int j = i + 1; j < ENTRIES; j++)
        if (slot_valid[i] && slot_valid[j] && slot_addr[i] == slot_addr[j])
          dup = 1'b1;
    end
  end

  a_r1_reset_quiet: assert property (@(posedge clk)
    rst |=> (!ready_valid && !full && !query_locked));

  a_r4_no_duplicate: assert property (@(posedge clk) disable iff (rst)
    !dup);

  a_r5_cleared_silent: assert property (@(posedge clk) disable iff (rst)
    (clear_valid && !(arm_valid && arm_addr == clear_addr))
      |=> ##1 !(ready_valid && ready_addr == $past(clear_addr, 2)));

  a_r7_full_holds: assert property (@(posedge clk) disable iff (rst)
    (full && arm_valid && !in_table && !clear_valid) |=> full);
endmodule

bind lockout_timer_table lockout_timer_table_chk #(
  .ADDR_W(ADDR_W), .ENTRIES(ENTRIES)
) u_chk (
  .clk(clk), .rst(rst), .arm_valid(arm_valid), .arm_addr(arm_addr),
  .clear_valid(clear_valid), .clear_addr(clear_addr),
  .query_locked(query_locked), .full(full), .ready_valid(ready_valid),
  .ready_addr(ready_addr), .slot_valid(slot_valid), .slot_addr(slot_addr)
);

// File: tb/lockout_timer_table_test.sv
module lockout_timer_table_test;
  localparam int AW = 16;
  localparam int L  = 12;
  localparam int NV = 4;
  localparam logic [AW-1:0] VA [NV] = '{16'h0100, 16'h0240, 16'h0388, 16'h04C0};
  localparam int            VG [NV] = '{0, 2, 5, 1};

  logic clk = 1'b0, rst = 1'b1;
  logic arm_valid = 1'b0, clear_valid = 1'b0;
  logic [AW-1:0] arm_addr = '0, clear_addr = '0, query_addr = '0;
  logic query_locked, full, ready_valid;
  logic [AW-1:0] ready_addr;

  int cyc = 0, total = 0, fails = 0, nlog = 0, last_arm = 0;
  logic [AW-1:0] log_addr [64];
  int            log_cyc  [64];
  int            t_arm    [NV];

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  lockout_timer_table #(.ADDR_W(AW), .ENTRIES(4), .LOCK_CYCLES(L)) uut (
    .clk(clk), .rst(rst), .arm_valid(arm_valid), .arm_addr(arm_addr),
    .clear_valid(clear_valid), .clear_addr(clear_addr),
    .query_addr(query_addr), .query_locked(query_locked), .full(full),
    .ready_valid(ready_valid), .ready_addr(ready_addr)
  );

  always @(negedge clk)
    if (!rst && ready_valid && nlog < 64) begin
      log_addr[nlog] = ready_addr;
      log_cyc[nlog]  = cyc;
      nlog++;
    end

  task automatic step(int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic check(string req, int act, int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic arm(logic [AW-1:0] a);
    arm_valid = 1'b1; arm_addr = a; last_arm = cyc;
    step(1);
    arm_valid = 1'b0;
  endtask

  task automatic clear(logic [AW-1:0] a);
    clear_valid = 1'b1; clear_addr = a;
    step(1);
    clear_valid = 1'b0;
  endtask

  task automatic query(logic [AW-1:0] a);
    query_addr = a;
    step(1);
  endtask

  function automatic int fires(logic [AW-1:0] a);
    int n = 0;
    for (int k = 0; k < nlog; k++) if (log_addr[k] == a) n++;
    return n;
  endfunction

  function automatic int fire_cyc(logic [AW-1:0] a);
    for (int k = 0; k < nlog; k++) if (log_addr[k] == a) return log_cyc[k];
    return -1;
  endfunction

  task automatic do_reset();
    rst = 1'b1;
    step(2);
    rst = 1'b0;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", total - fails, total);
  endtask

  initial begin
    #1_000_000;
    total++; fails++;
    $display("FAIL watchdog: actual hung expected done");
    summary();
    $finish;
  end

  initial begin
    step(1);
    check("R1 reset ready_valid", int'(ready_valid), 0);
    check("R1 reset full", int'(full), 0);
    check("R1 reset query_locked", int'(query_locked), 0);
    do_reset();
    check("R1 after release full", int'(full), 0);

    // table walk: staggered arms of distinct addresses
    for (int i = 0; i < NV; i++) begin
      step(VG[i]);
      arm(VA[i]);
      t_arm[i] = last_arm;
    end
    query(VA[0]);
    check("R8 locked during window", int'(query_locked), 1);
    check("R7 full after four arms", int'(full), 1);
    step(L + 10);
    for (int i = 0; i < NV; i++) begin
      check("R3 single pulse", fires(VA[i]), 1);
      check("R2 pulse cycle", fire_cyc(VA[i]), t_arm[i] + 1 + L);
    end
    query(VA[2]);
    check("R3 unlocked after pulse", int'(query_locked), 0);
    check("R7 fired entries still occupy", int'(full), 1);
    arm(16'h0500);
    step(L + 5);
    check("R7 arm while full ignored", fires(16'h0500), 0);
    for (int i = 0; i < NV; i++) clear(VA[i]);
    step(1);
    check("R5 clears free slots", int'(full), 0);

    // restart of a pending address
    arm(16'h0AAA);
    step(5);
    arm(16'h0AAA);
    t_arm[0] = last_arm;
    step(L + 8);
    check("R4 one pulse after restart", fires(16'h0AAA), 1);
    check("R4 pulse at restarted deadline", fire_cyc(16'h0AAA), t_arm[0] + 1 + L);
    clear(16'h0AAA);

    // clear before deadline
    arm(16'h0BBB);
    step(3);
    clear(16'h0BBB);
    query(16'h0BBB);
    check("R5 cleared not locked", int'(query_locked), 0);
    step(L + 5);
    check("R5 cleared never pulses", fires(16'h0BBB), 0);

    // arm and clear of the same address together
    arm(16'h0CCC);
    step(4);
    arm_valid = 1'b1; arm_addr = 16'h0CCC;
    clear_valid = 1'b1; clear_addr = 16'h0CCC;
    t_arm[1] = cyc;
    step(1);
    arm_valid = 1'b0; clear_valid = 1'b0;
    step(L + 6);
    check("R6 arm wins pulse count", fires(16'h0CCC), 1);
    check("R6 arm wins pulse cycle", fire_cyc(16'h0CCC), t_arm[1] + 1 + L);
    clear(16'h0CCC);

    // reset discards a pending entry
    arm(16'h0DDD);
    step(3);
    do_reset();
    step(L + 5);
    check("R1 reset discards pending", fires(16'h0DDD), 0);
    check("R1 reset empties table", int'(full), 0);

    summary();
    $finish;
  end
endmodule